// File: doc/BRIEF.md
# Serial IRQ Slave Request Controller

This block is the peripheral side of a shared serial interrupt line. Five interrupt sources belong to two host-interface channels: a system-management interrupt and interrupt numbers 6, 9, 10 and 11. Each source is qualified by a host enable bit. Unless direct mode is selected, it is also qualified by its output-buffer-full flag. The block follows the frames on the line, which is open-drain and pulled high. It drives a low pulse in the sample phase of each asserted source's slot. It drives high in the recovery phase and lets go in the turnaround phase.

The length of the host's stop frame selects quiet or continuous operation, and the block records the result in a read-only flag. In quiet mode the block may open a frame itself by pulling the idle line low for one clock. The host then carries the start frame on. A policy bit decides whether this happens on any single request clearing or only when the last request clears. A new request always starts a frame in quiet mode. In continuous mode the block only answers frames that the host starts.

A bench clock cycle is called a step. The host drives the line during a step, and the block's own drive for that step comes from a register loaded at the clock edge that begins it.

Top module: `sirq_slave`

## Requirements
- R1: After reset the line is released (`sirq_oe`=0), the mode flag reads continuous (0), and both policy bits read 0.
- R2: With direct mode off, a source is reported only when both its enable bit and its buffer-full flag are 1.
- R3: With direct mode on, a source is reported whenever its enable bit is 1, whatever its buffer-full flag says.
- R4: A start frame is a run of at least 4 low steps. Call the first high step after it step t. Slot n has its sample phase at step t+2+3n. The sources sit in fixed slots: source 0 (SMI) in slot 2, source 1 (IRQ6) in slot 6, and sources 2 to 4 (IRQ9 to IRQ11) in slots 9 to 11.
- R5: For a reported source, the block drives low in the sample step, drives high (`sirq_oe`=1, `sirq_o`=1) in the recovery step and releases in the turnaround step. Unreported slots stay released throughout.
- R6: The stop frame follows the last slot's turnaround. Exactly 2 low steps set the mode flag to quiet (1), exactly 3 set it to continuous (0), and any other count leaves it unchanged. The new value is readable one step after the first high step.
- R7: A software reset pulse clears the mode flag to continuous.
- R8: In quiet mode with the any-clear policy off, a start request is made only when the set of reported sources goes from non-empty to empty. A partial clear makes none.
- R9: In quiet mode with the any-clear policy on, a start request is made when any one reported source clears.
- R10: In quiet mode, a source that newly becomes reported makes a start request.
- R11: A start request caused by an input change in step k drives the line low for exactly step k+2, if the line is idle and high. The line is released in the next step.
- R12: In continuous mode the block never drives the line outside slot phases, whatever the inputs do.
- R13: The control read word is bit0 = direct mode, bit1 = any-clear policy, bit2 = mode flag. Writes set only bits 0 and 1. The mode flag has no write path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial IRQ clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lpc_sw_rst | input | 1 | Software reset; clears the mode flag and frame tracking |
| cfg_we | input | 1 | Write strobe for the policy bits |
| cfg_wdata | input | 2 | bit0 direct mode, bit1 any-clear policy |
| cfg_rdata | output | 3 | {mode flag, any-clear, direct} |
| src_en | input | 5 | Host enable bit per source |
| src_obf | input | 5 | Output-buffer-full flag per source |
| sirq_i | input | 1 | Resolved level of the serial IRQ line |
| sirq_oe | output | 1 | Drive enable for the line |
| sirq_o | output | 1 | Level driven when enabled |

## Verification
A wrong slot or phase counter shows up at the ports as a low pulse in the wrong step. The mismatch appears in the first slot after the start frame, within three steps of the fault. A wrong stop-count decode or a lost mode flag appears in the read word one step after the stop frame ends. It also shows up as a start pulse that is missing, or that should not be there. A faulty pending-request state shows up exactly two steps after the input change, as a start pulse that is absent or unexpected.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NSRC = 5;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_TURN0 = 2'd1,
    FR_SLOT  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_e;

  // slot number of each source: SMI, IRQ6, IRQ9, IRQ10, IRQ11
  function automatic int slot_of_src(input int idx);
    case (idx)
      0:       return 2;
      1:       return 6;
      2:       return 9;
      3:       return 10;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/sirq_cfg.sv
module sirq_cfg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic       direct,
  output logic       anyclear
);
  always_ff @(posedge clk) begin
    if (rst) begin
      direct   <= 1'b0;
      anyclear <= 1'b0;
    end else if (we) begin
      direct   <= wdata[0];
      anyclear <= wdata[1];
    end
  end
endmodule

// File: rtl/sirq_req.sv
module sirq_req #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_rst,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] obf,
  input  logic            direct,
  input  logic            anyclear,
  input  logic            quiet,
  input  logic            ack,
  output logic [NSRC-1:0] req_q,
  output logic            pend
);
  logic [NSRC-1:0] qual;
  logic            rose, fell_any, all_clr, trig;

  always_comb begin
    qual     = en & (obf | {NSRC{direct}});
    rose     = |(qual & ~req_q);
    fell_any = |(req_q & ~qual);
    all_clr  = (|req_q) & ~(|qual);
    trig     = quiet & (rose | (anyclear ? fell_any : all_clr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else begin
      req_q <= qual;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst || !quiet) begin
      pend <= 1'b0;
    end else if (trig) begin
      pend <= 1'b1;
    end else if (ack) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sirq_frame.sv
module sirq_frame
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int START_MIN = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_rst,
  input  logic                 line_i,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  logic                 pend,
  output logic                 quiet,
  output logic                 start_ack,
  output logic                 start_seen,
  output logic                 in_stop,
  output logic                 drv_start,
  output logic                 sirq_oe,
  output logic                 sirq_o
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W  = $clog2(START_MIN + 1) + 1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_START = CNT_W'(START_MIN);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  fr_state_e         state, st_n;
  logic [SLOT_W-1:0] slot_idx, slot_n;
  logic [1:0]        phase, ph_n;
  logic [CNT_W-1:0]  lowcnt, cnt_n, cnt_inc;
  logic              hit_q, hit_n;
  logic              quiet_n;
  logic              oe_n, o_n, go_n;

  always_comb begin
    st_n       = state;
    slot_n     = slot_idx;
    ph_n       = phase;
    cnt_n      = lowcnt;
    hit_n      = hit_q;
    quiet_n    = quiet;
    oe_n       = 1'b0;
    o_n        = 1'b1;
    go_n       = 1'b0;
    start_ack  = 1'b0;
    start_seen = 1'b0;
    cnt_inc    = (lowcnt == CNT_MAX) ? lowcnt : lowcnt + 1'b1;
    case (state)
      FR_IDLE: begin
        if (!line_i) begin
          cnt_n = cnt_inc;
        end else begin
          cnt_n = '0;
          if (lowcnt >= CNT_START) begin
            st_n       = FR_TURN0;
            start_seen = 1'b1;
          end else if (quiet && pend && lowcnt == '0) begin
            oe_n      = 1'b1;
            o_n       = 1'b0;
            go_n      = 1'b1;
            start_ack = 1'b1;
          end
        end
      end
      FR_TURN0: begin
        st_n   = FR_SLOT;
        slot_n = '0;
        ph_n   = 2'd0;
        hit_n  = slot_req[0];
        oe_n   = hit_n;
        o_n    = 1'b0;
      end
      FR_SLOT: begin
        if (phase == 2'd0) begin
          ph_n = 2'd1;
          oe_n = hit_q;
          o_n  = 1'b1;
        end else if (phase == 2'd1) begin
          ph_n = 2'd2;
        end else if (slot_idx == LAST_SLOT) begin
          st_n  = FR_STOP;
          cnt_n = '0;
        end else begin
          slot_n = slot_idx + 1'b1;
          ph_n   = 2'd0;
          hit_n  = slot_req[slot_n];
          oe_n   = hit_n;
          o_n    = 1'b0;
        end
      end
      default: begin
        if (!line_i) begin
          cnt_n = cnt_inc;
        end else if (lowcnt != '0) begin
          if (lowcnt == CNT_W'(2)) begin
            quiet_n = 1'b1;
          end else if (lowcnt == CNT_W'(3)) begin
            quiet_n = 1'b0;
          end
          st_n  = FR_IDLE;
          cnt_n = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      state     <= FR_IDLE;
      slot_idx  <= '0;
      phase     <= 2'd0;
      lowcnt    <= '0;
      hit_q     <= 1'b0;
      quiet     <= 1'b0;
      sirq_oe   <= 1'b0;
      sirq_o    <= 1'b1;
      drv_start <= 1'b0;
    end else begin
      state     <= st_n;
      slot_idx  <= slot_n;
      phase     <= ph_n;
      lowcnt    <= cnt_n;
      hit_q     <= hit_n;
      quiet     <= quiet_n;
      sirq_oe   <= oe_n;
      sirq_o    <= o_n;
      drv_start <= go_n;
    end
  end

  assign in_stop = (state == FR_STOP);
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
  import sirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int START_MIN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lpc_sw_rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_wdata,
  output logic [2:0]      cfg_rdata,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_obf,
  input  logic            sirq_i,
  output logic            sirq_oe,
  output logic            sirq_o
);
  logic                 direct, anyclear, quiet;
  logic [NSRC-1:0]      req_q;
  logic [NUM_SLOTS-1:0] slot_req;
  logic                 pend, start_ack, start_seen, in_stop, drv_start;

  sirq_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .direct   (direct),
    .anyclear (anyclear)
  );

  sirq_req #(.NSRC(NSRC)) u_req (
    .clk      (clk),
    .rst      (rst),
    .sw_rst   (lpc_sw_rst),
    .en       (src_en),
    .obf      (src_obf),
    .direct   (direct),
    .anyclear (anyclear),
    .quiet    (quiet),
    .ack      (start_ack | start_seen),
    .req_q    (req_q),
    .pend     (pend)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        if (slot_of_src(i) == s) hit = hit | req_q[i];
      end
    end
    assign slot_req[s] = hit;
  end

  sirq_frame #(.NUM_SLOTS(NUM_SLOTS), .START_MIN(START_MIN)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .sw_rst     (lpc_sw_rst),
    .line_i     (sirq_i),
    .slot_req   (slot_req),
    .pend       (pend),
    .quiet      (quiet),
    .start_ack  (start_ack),
    .start_seen (start_seen),
    .in_stop    (in_stop),
    .drv_start  (drv_start),
    .sirq_oe    (sirq_oe),
    .sirq_o     (sirq_o)
  );

  assign cfg_rdata = {quiet, anyclear, direct};
endmodule

// File: rtl/sirq_slave_chk.sv
module sirq_slave_chk #(
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            sw_rst,
  input logic            sirq_oe,
  input logic            sirq_o,
  input logic            drv_start,
  input logic            quiet,
  input logic            in_stop,
  input logic            direct,
  input logic [NSRC-1:0] src_obf,
  input logic [NSRC-1:0] req_q
);
  // R5: a recovery-phase high drive is always followed by release
  p_recovery_release_r5: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (sirq_oe && sirq_o) |=> !sirq_oe);

  // R5: a slot sample low is always followed by a high recovery drive
  p_sample_recovery_r5: assert property (@(posedge clk) disable iff (rst || sw_rst)
    (sirq_oe && !sirq_o && !drv_start) |=> (sirq_oe && sirq_o));

  // R12: the block opens a frame only in quiet mode
  p_start_quiet_r12: assert property (@(posedge clk) disable iff (rst || sw_rst)
    drv_start |-> quiet);

  // R11: a start pulse lasts one step
  p_start_single_r11: assert property (@(posedge clk) disable iff (rst || sw_rst)
    drv_start |=> !sirq_oe);

  // R6: the mode flag moves only when a stop frame ends, or on software reset
  p_mode_stop_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(quiet) |-> ($past(in_stop) || $past(sw_rst)));

  // R2: with direct mode off, no source is reported without its buffer-full flag
  p_qual_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!direct) |-> ((req_q & ~$past(src_obf)) == '0));
endmodule

bind sirq_slave sirq_slave_chk #(.NSRC(sirq_pkg::NSRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_rst    (lpc_sw_rst),
  .sirq_oe   (sirq_oe),
  .sirq_o    (sirq_o),
  .drv_start (drv_start),
  .quiet     (quiet),
  .in_stop   (in_stop),
  .direct    (direct),
  .src_obf   (src_obf),
  .req_q     (req_q)
);

// File: tb/sirq_slave_tb_top.sv
module sirq_slave_tb_top;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rst, sw, we;
  logic [1:0] wdata;
  wire  [2:0] rdata;
  logic [4:0] en, obf;
  logic       host_low;
  wire        oe, o;
  wire        line;

  int checks = 0;
  int errors = 0;
  bit direct_m = 0, anyclear_m = 0, quiet_m = 0;

  always #10 clk = ~clk;

  assign line = ~(host_low | (oe & ~o));

  sirq_slave #(.NUM_SLOTS(NS), .START_MIN(4)) dut_i (
    .clk(clk), .rst(rst), .lpc_sw_rst(sw), .cfg_we(we), .cfg_wdata(wdata),
    .cfg_rdata(rdata), .src_en(en), .src_obf(obf), .sirq_i(line),
    .sirq_oe(oe), .sirq_o(o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_slots();
    int map [5] = '{2, 6, 9, 10, 11};
    logic [NS-1:0] v = '0;
    for (int i = 0; i < 5; i++)
      if (en[i] && (obf[i] || direct_m)) v[map[i]] = 1'b1;
    return v;
  endfunction

  // one step: check this step's drive, then set the host drive for it
  task automatic step(input bit h, input bit e_oe, input bit e_o, input string req);
    @(negedge clk);
    chk(oe == e_oe, req, "drive enable", int'(oe), int'(e_oe));
    if (e_oe) chk(o == e_o, req, "drive level", int'(o), int'(e_o));
    host_low = h;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 1, req);
  endtask

  task automatic set_src(input logic [4:0] e, input logic [4:0] f);
    step(0, 0, 1, "R12");
    en  = e;
    obf = f;
  endtask

  task automatic wr(input logic [1:0] d);
    step(0, 0, 1, "R13");
    we = 1'b1; wdata = d;
    step(0, 0, 1, "R13");
    we = 1'b0;
    direct_m = d[0]; anyclear_m = d[1];
  endtask

  task automatic rd(input string req);
    @(negedge clk);
    chk(rdata == {quiet_m, anyclear_m, direct_m}, req, "read word",
        int'(rdata), int'({quiet_m, anyclear_m, direct_m}));
  endtask

  task automatic frame(input bit joined, input int stop_len, input string req);
    logic [NS-1:0] v;
    v = exp_slots();
    for (int i = 0; i < (joined ? 3 : 4); i++) step(1, 0, 1, req);
    step(0, 0, 1, req);            // recovery of start frame
    step(0, 0, 1, req);            // turnaround of start frame
    for (int n = 0; n < NS; n++) begin
      step(0, v[n], 0, "R4");      // sample
      step(0, v[n], 1, "R5");      // recovery
      step(0, 0, 1, "R5");         // turnaround
    end
    for (int i = 0; i < stop_len; i++) step(1, 0, 1, "R6");
    step(0, 0, 1, "R6");
    if (stop_len == 2) quiet_m = 1;
    else if (stop_len == 3) quiet_m = 0;
    rd("R6");
  endtask

  // input change in step k: release in k+1, start pulse in k+2
  task automatic expect_start(input bit yes, input string req);
    step(0, 0, 1, req);
    if (yes) begin
      step(1, 1, 0, "R11");
      frame(1, 2, req);
    end else begin
      idle(4, req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; sw = 0; we = 0; wdata = 0; en = 0; obf = 0; host_low = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    @(negedge clk);
    chk(oe == 1'b0, "R1", "released after reset", int'(oe), 0);
    chk(rdata == 3'b000, "R1", "read word after reset", int'(rdata), 0);

    // R2 and R4: qualification with buffer-full flags, continuous mode
    set_src(5'b11111, 5'b10101);
    idle(3, "R12");
    frame(0, 3, "R2");

    // R3: direct mode ignores buffer-full flags
    wr(2'b01);
    idle(3, "R3");
    frame(0, 3, "R3");

    // R6: stop of 4 keeps continuous, stop of 2 selects quiet
    frame(0, 4, "R6");
    frame(0, 2, "R6");
    rd("R13");

    // R8: all-clear policy: partial clear gives no start, full clear does
    set_src(5'b11110, 5'b10101);
    expect_start(0, "R8");
    set_src(5'b00000, 5'b10101);
    expect_start(1, "R8");

    // R10: a new request starts a frame in quiet mode
    set_src(5'b00001, 5'b10101);
    expect_start(1, "R10");

    // R9: any-clear policy
    wr(2'b11);
    rd("R13");
    set_src(5'b00011, 5'b10101);
    expect_start(1, "R10");
    set_src(5'b00010, 5'b10101);
    expect_start(1, "R9");

    // R7: software reset clears the mode flag
    @(negedge clk); sw = 1;
    @(negedge clk); sw = 0;
    quiet_m = 0;
    rd("R7");

    // R12: continuous mode never opens a frame
    set_src(5'b00000, 5'b10101);
    idle(6, "R12");
    set_src(5'b11111, 5'b00000);
    idle(6, "R12");

    // R13 and R2: clear direct mode, then check flags again
    wr(2'b00);
    rd("R13");
    set_src(5'b11111, 5'b01010);
    idle(3, "R2");
    frame(0, 3, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule